// File: doc/BRIEF.md
# Mailbox Message Queue

This block holds the words travelling in one direction of a mailbox between two processors. A producer appends 32-bit words at the tail. A consumer takes a word out of the queue by naming its position. The head is usually position zero, but any occupied position can be taken. When a word is taken, every word behind it moves one place toward the head, and the highest slot that this frees is loaded with a reserved marker value. As a result, any slot that holds no message always reads as that marker.

The consumer can look at the head word without removing it. While the queue is empty, that look returns the marker. A live count of stored words is provided, together with a 32-bit status word. The status word carries a full flag, an empty flag and the fill level at fixed bit positions. A take and an append in the same clock are applied take first, so a full queue can still accept a word in that cycle. A request that cannot be honoured is dropped and raises a one-cycle error pulse.

Top module: `mbox_msg_queue`

## Requirements
- R1: While reset is asserted, and after it is released, the count is zero, every slot holds the marker (default 32'hFFFF_FFFF), the status word equals 32'h4000_0000 and the error output is low.
- R2: Status bit 31 is high exactly when the count equals DEPTH (default 8). Status bit 30 is high exactly when the count is zero. Bits 29:8 are zero.
- R3: Status bits 7:0 hold the current count.
- R4: An accepted append stores the word at the position equal to the count before the append, and the count then rises by one on the next clock edge.
- R5: `pop_data_o` shows, combinationally, the slot chosen by `pop_idx_i`. An accepted take at index i (i < count) removes that word, moves each later word down one position and lowers the count by one.
- R6: After a take, the freed top slot holds the marker. A slot at or above the count always reads as the marker.
- R7: `peek_o` shows the head word without removing it, and shows the marker when the queue is empty.
- R8: An append that finds the queue full (after any take in the same cycle) is dropped and leaves the stored words unchanged. `err_o` goes high in the following cycle.
- R9: A take with `pop_idx_i` greater than or equal to the count, including any take from an empty queue, is dropped and leaves the stored words unchanged. `err_o` goes high in the following cycle.
- R10: When an append and a valid take arrive together, the take is applied first. A full queue therefore accepts the new word, the count stays at DEPTH and no error is raised.
- R11: `err_o` is high for exactly one cycle per dropped request and is low after any cycle whose requests were all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Append request |
| push_data_i | input | 32 | Word to append |
| pop_i | input | 1 | Take request |
| pop_idx_i | input | 3 | Position to take |
| pop_data_o | output | 32 | Word at `pop_idx_i` |
| peek_o | output | 32 | Head word, or the marker when empty |
| count_o | output | 4 | Number of stored words |
| status_o | output | 32 | Full flag (bit 31), empty flag (bit 30), level (bits 7:0) |
| err_o | output | 1 | One-cycle pulse after a dropped request |

## Verification
The bench keeps a behavioural queue and compares the outputs with it after every clock. Its stimulus concentrates on the places where this block is most likely to go wrong.

Takes from the middle and from the top of the queue catch a compaction that overwrites the wrong slot, which would show up later as duplicated or lost words. Reads at or above the count catch a freed slot that still holds its stale word instead of the marker. An append combined with a take on a full queue catches a design that checks for full before the take is applied; such a design would wrongly drop the word and pulse the error. Appends to a full queue and takes at invalid positions catch a design that changes the stored words, or forgets to pulse the error, when it drops a request.

// File: rtl/mbq_pkg.sv
package mbq_pkg;
  localparam int unsigned STAT_W        = 32;
  localparam int unsigned STAT_FULL_POS = 31;
  localparam int unsigned STAT_EMPT_POS = 30;
  localparam int unsigned STAT_LVL_W    = 8;

  function automatic logic [STAT_W-1:0] pack_status(input logic full,
                                                    input logic empty,
                                                    input logic [STAT_LVL_W-1:0] lvl);
    logic [STAT_W-1:0] s;
    s                = '0;
    s[STAT_FULL_POS] = full;
    s[STAT_EMPT_POS] = empty;
    s[STAT_LVL_W-1:0] = lvl;
    return s;
  endfunction
endpackage

// File: rtl/mbq_ctrl.sv
module mbq_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [IDX_W-1:0] pop_idx_i,
  output logic             pop_ok_o,
  output logic             push_ok_o,
  output logic [CNT_W-1:0] wr_idx_o,
  output logic [CNT_W-1:0] count_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_mid;
  logic             err_q, err_d;
  logic             cnt_en;

  always_comb begin
    pop_ok_o  = pop_i && (CNT_W'(pop_idx_i) < cnt_q);
    cnt_mid   = cnt_q - CNT_W'(pop_ok_o);
    push_ok_o = push_i && (cnt_mid < CNT_W'(DEPTH));
    wr_idx_o  = cnt_mid;
    cnt_d     = cnt_mid + CNT_W'(push_ok_o);
    cnt_en    = pop_ok_o || push_ok_o;
    err_d     = (pop_i && !pop_ok_o) || (push_i && !push_ok_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign count_o = cnt_q;
  assign err_o   = err_q;
endmodule

// File: rtl/mbq_store.sv
module mbq_store #(
  parameter int unsigned          DEPTH   = 8,
  parameter int unsigned          DATA_W  = 32,
  parameter logic [DATA_W-1:0]    INVALID = '1,
  parameter int unsigned          CNT_W   = 4,
  parameter int unsigned          IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_ok_i,
  input  logic [IDX_W-1:0]  pop_idx_i,
  input  logic              push_ok_i,
  input  logic [CNT_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] head_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DATA_W-1:0] slot_d [DEPTH];
  logic              slot_en;

  assign slot_en = pop_ok_i || push_ok_i;

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic [DATA_W-1:0] shifted;
    if (j == DEPTH - 1) begin : g_top
      always_comb begin
        shifted = slot_q[j];
        if (pop_ok_i && (IDX_W'(j) >= pop_idx_i)) shifted = INVALID;
      end
    end else begin : g_mid
      always_comb begin
        shifted = slot_q[j];
        if (pop_ok_i && (IDX_W'(j) >= pop_idx_i)) shifted = slot_q[j+1];
      end
    end

    always_comb begin
      slot_d[j] = shifted;
      if (push_ok_i && (wr_idx_i == CNT_W'(j))) slot_d[j] = push_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[j] <= INVALID;
      end else if (slot_en) begin
        slot_q[j] <= slot_d[j];
      end
    end
  end

  assign rd_data_o = slot_q[pop_idx_i];
  assign head_o    = slot_q[0];
endmodule

// File: rtl/mbq_status.sv
module mbq_status
  import mbq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic [CNT_W-1:0]  count_i,
  output logic [STAT_W-1:0] status_o
);
  logic full, empty;
  logic [STAT_LVL_W-1:0] lvl;

  always_comb begin
    full     = (count_i == CNT_W'(DEPTH));
    empty    = (count_i == '0);
    lvl      = STAT_LVL_W'(count_i);
    status_o = pack_status(full, empty, lvl);
  end
endmodule

// File: rtl/mbox_msg_queue.sv
module mbox_msg_queue #(
  parameter int unsigned       DEPTH   = 8,
  parameter int unsigned       DATA_W  = 32,
  parameter logic [DATA_W-1:0] INVALID = 32'hFFFF_FFFF,
  localparam int unsigned      CNT_W   = $clog2(DEPTH + 1),
  localparam int unsigned      IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic [IDX_W-1:0]  pop_idx_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [DATA_W-1:0] peek_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [31:0]       status_o,
  output logic              err_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_sync;
  logic             pop_ok, push_ok;
  logic [CNT_W-1:0] wr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_sync_q[1];

  mbq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .pop_idx_i (pop_idx_i),
    .pop_ok_o  (pop_ok),
    .push_ok_o (push_ok),
    .wr_idx_o  (wr_idx),
    .count_o   (count_o),
    .err_o     (err_o)
  );

  mbq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .INVALID(INVALID),
              .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .pop_ok_i    (pop_ok),
    .pop_idx_i   (pop_idx_i),
    .push_ok_i   (push_ok),
    .wr_idx_i    (wr_idx),
    .push_data_i (push_data_i),
    .rd_data_o   (pop_data_o),
    .head_o      (peek_o)
  );

  mbq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
    .count_i  (count_o),
    .status_o (status_o)
  );
endmodule

// File: rtl/mbq_checker.sv
module mbq_checker #(
  parameter int unsigned       DEPTH   = 8,
  parameter int unsigned       DATA_W  = 32,
  parameter logic [DATA_W-1:0] INVALID = '1,
  parameter int unsigned       CNT_W   = 4,
  parameter int unsigned       IDX_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic [IDX_W-1:0]  pop_idx_i,
  input logic [DATA_W-1:0] peek_o,
  input logic [CNT_W-1:0]  count_o,
  input logic [31:0]       status_o,
  input logic              err_o
);
  logic idx_ok;
  assign idx_ok = CNT_W'(pop_idx_i) < count_o;

  a_r2_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31] == (count_o == CNT_W'(DEPTH)));
  a_r2_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[30] == (count_o == '0));
  a_r3_level: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7:0] == 8'(count_o));
  a_r4_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && count_o < CNT_W'(DEPTH)) |=> (count_o == $past(count_o) + 1'b1));
  a_r5_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && idx_ok) |=> (count_o == $past(count_o) - 1'b1));
  a_r7_peek_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0) |-> (peek_o == INVALID));
  a_r8_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && count_o == CNT_W'(DEPTH)) |=> (err_o && $stable(count_o)));
  a_r9_bad_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !idx_ok) |=> (err_o && $stable(count_o)));
  a_r10_swap_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && idx_ok && count_o == CNT_W'(DEPTH)) |=> (count_o == CNT_W'(DEPTH) && !err_o));
  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> !err_o);
endmodule

bind mbox_msg_queue mbq_checker #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .INVALID(INVALID), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .pop_idx_i (pop_idx_i),
  .peek_o    (peek_o),
  .count_o   (count_o),
  .status_o  (status_o),
  .err_o     (err_o)
);

// File: tb/sim_mbox_msg_queue.sv
`timescale 1ns/1ps
module sim_mbox_msg_queue;
  localparam int          DEPTH   = 8;
  localparam logic [31:0] INVALID = 32'hFFFF_FFFF;

  logic        clk, rst_n, push, pop, err;
  logic [31:0] din, pop_data, peek, status;
  logic [2:0]  pidx;
  logic [3:0]  count;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] mq[$];
  bit exp_err;
  string err_tag;

  mbox_msg_queue u0 (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(din),
    .pop_i(pop), .pop_idx_i(pidx), .pop_data_o(pop_data), .peek_o(peek),
    .count_o(count), .status_o(status), .err_o(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = '0;
    s[31] = (mq.size() == DEPTH);
    s[30] = (mq.size() == 0);
    s[7:0] = 8'(mq.size());
    return s;
  endfunction

  task automatic check_state();
    check("R4 R5 count", 32'(count), 32'(mq.size()));
    check("R2 R3 status", status, exp_status());
    check("R7 peek", peek, (mq.size() > 0) ? mq[0] : INVALID);
    check(err_tag, 32'(err), 32'(exp_err));
  endtask

  task automatic step(input bit p, input logic [31:0] d, input bit q, input int idx);
    bit pop_ok, push_ok;
    @(negedge clk);
    push = p; din = d; pop = q; pidx = 3'(idx);
    #1;
    if (q) begin
      if (idx < mq.size()) check("R5 pop data", pop_data, mq[idx]);
      else                 check("R6 vacant slot marker", pop_data, INVALID);
    end
    pop_ok = q && (idx < mq.size());
    if (pop_ok) mq.delete(idx);
    push_ok = p && (mq.size() < DEPTH);
    if (push_ok) mq.push_back(d);
    exp_err = (q && !pop_ok) || (p && !push_ok);
    if (p && !push_ok)      err_tag = "R8 err on full push";
    else if (q && !pop_ok)  err_tag = "R9 err on bad pop";
    else if (p && q)        err_tag = "R10 combined op";
    else                    err_tag = "R11 err quiet";
    @(posedge clk);
    #1;
    check_state();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; push = 1'b0; pop = 1'b0; din = '0; pidx = '0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", 32'(count), 0);
    check("R1 peek in reset", peek, INVALID);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 count", 32'(count), 0);
    check("R1 status", status, 32'h4000_0000);
    check("R1 peek", peek, INVALID);
    check("R1 err", 32'(err), 0);
    err_tag = "R11 err quiet";

    // R4 appends, R5 take from the middle, R6 freed slot
    step(1, 32'h1111_0001, 0, 0);
    step(1, 32'h1111_0002, 0, 0);
    step(1, 32'h1111_0003, 0, 0);
    step(0, 0, 1, 1);
    step(0, 0, 1, 2);                 // R6/R9: index now beyond count
    step(0, 0, 1, 1);                 // R5 top entry
    step(0, 0, 1, 0);                 // R5 drains to empty
    step(0, 0, 1, 0);                 // R9 empty take
    // R2 fill to full, R8 push when full
    for (int k = 0; k < DEPTH; k++) step(1, 32'hA000_0000 + k, 0, 0);
    step(1, 32'hDEAD_BEEF, 0, 0);
    // R10 take and append on full queue
    step(1, 32'hB000_0001, 1, 3);
    step(1, 32'hB000_0002, 1, 7);
    step(1, 32'hB000_0003, 1, 0);
    // drain from the top down, R6
    for (int k = DEPTH - 1; k >= 0; k--) step(0, 0, 1, k);
    step(1, 32'hC000_0000, 1, 0);     // R9 + push on empty
    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      step(($urandom % 3) != 0, $urandom, ($urandom % 2) == 0, $urandom % DEPTH);
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule